// File: doc/BRIEF.md
# Minute Alarm and Seconds Tick Interrupt Unit

This unit watches a running BCD clock and raises two level interrupts. The first is an alarm that fires when the time reaches second zero of a chosen minute and hour, on any weekday picked from a seven-bit one-hot mask. The second is a tick interrupt that is raised on every seconds increment. Software that needs an alarm on a particular second enables the tick once the right minute has arrived and counts seconds itself.

The time counter feeds the unit with the current seconds, minutes and hours in BCD, a weekday number from 0 to 6, and a one-cycle strobe. The strobe marks the cycle in which those inputs first show the new second. A small register port gives write access to the alarm minute, the alarm hour, the weekday mask, the two enable bits and a write-one-to-clear status register. It also reads them back combinationally. Each interrupt line stays high until software clears its status bit.

Top module: `alm_irq_unit`

## Requirements
- R1: After reset both interrupt lines are low and every register address reads 0.
- R2: Register map: address 0 is control (bit 4 alarm enable, bit 3 tick enable, other bits read 0); address 1 is the alarm minute (bits 6:0 kept); address 2 is the alarm hour (bits 5:0 kept); address 3 is the weekday mask (bits 6:0 kept, bit n selects weekday n); address 4 is status (bit 0 alarm, bit 1 tick); addresses 5 to 7 read 0.
- R3: When the alarm is enabled, a strobe cycle with seconds 0x00, minute equal to the alarm minute, hour equal to the alarm hour, and the mask bit of the current weekday set drives `irq_alarm` high from the next cycle.
- R4: No alarm is raised if any part of that condition fails: a minute or hour mismatch, a clear mask bit, nonzero seconds, no strobe, or weekday 7, which has no mask bit.
- R5: When the tick is enabled, every strobe cycle drives `irq_tick` high from the next cycle, whatever the seconds value.
- R6: A raised line stays high until a write to status with a 1 in its bit clears it in the next cycle. Writing 0 to that bit, or writing 1 to the other bit, leaves it high.
- R7: When an event and a clearing write of the same bit happen in the same cycle, the event wins and the line stays high.
- R8: An event that occurs while its enable is clear is not recorded, so setting the enable later does not raise the line.
- R9: A control write that clears an enable bit drops that line and its pending status in the next cycle, even if an event arrives in the same cycle. Writing 0 to control silences both lines.
- R10: The two lines are independent. An alarm strobe with both enables set raises both lines, and each is cleared by its own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe: time inputs show a new second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_wday | input | 3 | Current weekday 0..6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq_alarm | output | 1 | Alarm interrupt, level |
| irq_tick | output | 1 | Seconds tick interrupt, level |

## Verification
A corrupted alarm field shows up at once on the register readback. It shows again one cycle after the next matching strobe, as a missing or extra `irq_alarm`. A status flag that sets or clears wrongly shows on its interrupt line in the cycle after the strobe or status write that should have changed it. The weekday vector table covers each way the match can fail, so a broken mask decode or comparator appears on the first row that depends on it. The same-cycle collisions between an event and a status clear, or between an event and an enable clear, cover the priority order of the flags.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int BCD_W     = 8;
    localparam int WDAY_N    = 7;
    localparam int WDAY_W    = $clog2(WDAY_N + 1);
    localparam int ADDR_W    = 3;
    localparam int IRQ_N     = 2;
    localparam int MIN_KEEP  = 7;
    localparam int HOUR_KEEP = 6;

    // Control bit positions decoded by software
    localparam int EN_ALM_BIT  = 4;
    localparam int EN_TICK_BIT = 3;

    // Channel index == status bit position
    localparam int CH_ALM  = 0;
    localparam int CH_TICK = 1;

    typedef enum logic [ADDR_W-1:0] {
        RS_CTRL  = 3'd0,
        RS_AMIN  = 3'd1,
        RS_AHOUR = 3'd2,
        RS_AMASK = 3'd3,
        RS_STAT  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [BCD_W-1:0]  sec;
        logic [BCD_W-1:0]  min;
        logic [BCD_W-1:0]  hour;
        logic [WDAY_W-1:0] wday;
    } now_t;

    typedef struct packed {
        logic              alm_en;
        logic              tick_en;
        logic [BCD_W-1:0]  amin;
        logic [BCD_W-1:0]  ahour;
        logic [WDAY_N-1:0] amask;
    } cfg_t;

    function automatic logic [BCD_W-1:0] keep_low(input logic [BCD_W-1:0] v, input int n);
        logic [BCD_W-1:0] r;
        for (int i = 0; i < BCD_W; i++) begin
            r[i] = (i < n) ? v[i] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BCD_W-1:0]  reg_wdata,
    input  logic [IRQ_N-1:0]  stat,
    output cfg_t              cfg,
    output logic [IRQ_N-1:0]  w1c,
    output logic [IRQ_N-1:0]  kill,
    output logic [BCD_W-1:0]  rdata
);

    logic wr_ctrl;
    logic wr_stat;

    assign wr_ctrl = reg_wr && (reg_addr == RS_CTRL);
    assign wr_stat = reg_wr && (reg_addr == RS_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RS_CTRL: begin
                    cfg.alm_en  <= reg_wdata[EN_ALM_BIT];
                    cfg.tick_en <= reg_wdata[EN_TICK_BIT];
                end
                RS_AMIN:  cfg.amin  <= keep_low(reg_wdata, MIN_KEEP);
                RS_AHOUR: cfg.ahour <= keep_low(reg_wdata, HOUR_KEEP);
                RS_AMASK: cfg.amask <= reg_wdata[WDAY_N-1:0];
                default: ;
            endcase
        end
    end

    // Clearing strobes toward the flag bank
    always_comb begin
        for (int i = 0; i < IRQ_N; i++) begin
            w1c[i] = wr_stat && reg_wdata[i];
        end
        kill[CH_ALM]  = wr_ctrl && !reg_wdata[EN_ALM_BIT];
        kill[CH_TICK] = wr_ctrl && !reg_wdata[EN_TICK_BIT];
    end

    always_comb begin
        rdata = '0;
        case (reg_addr)
            RS_CTRL: begin
                rdata[EN_ALM_BIT]  = cfg.alm_en;
                rdata[EN_TICK_BIT] = cfg.tick_en;
            end
            RS_AMIN:  rdata = cfg.amin;
            RS_AHOUR: rdata = cfg.ahour;
            RS_AMASK: rdata = BCD_W'(cfg.amask);
            RS_STAT:  rdata = BCD_W'(stat);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  logic             sec_tick,
    input  now_t             now,
    input  cfg_t             cfg,
    output logic [IRQ_N-1:0] evt
);

    logic [WDAY_N-1:0] day_hit;
    logic              sec_zero;
    logic              hm_equal;

    generate
        for (genvar d = 0; d < WDAY_N; d++) begin : g_day
            assign day_hit[d] = cfg.amask[d] && (now.wday == WDAY_W'(d));
        end
    endgenerate

    assign sec_zero = (now.sec == '0);
    assign hm_equal = (now.min == cfg.amin) && (now.hour == cfg.ahour);

    assign evt[CH_ALM]  = sec_tick && sec_zero && hm_equal && (|day_hit);
    assign evt[CH_TICK] = sec_tick;

endmodule

// File: rtl/alm_flags.sv
module alm_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] en,
    input  logic [N-1:0] w1c,
    input  logic [N-1:0] kill,
    output logic [N-1:0] stat,
    output logic [N-1:0] irq
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            logic flag;
            // priority: enable clear > new event > software clear
            always_ff @(posedge clk) begin
                if (rst)                  flag <= 1'b0;
                else if (kill[i])         flag <= 1'b0;
                else if (evt[i] && en[i]) flag <= 1'b1;
                else if (w1c[i])          flag <= 1'b0;
            end
            assign stat[i] = flag;
            assign irq[i]  = flag && en[i];
        end
    endgenerate

endmodule

// File: rtl/alm_irq_unit.sv
module alm_irq_unit
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [BCD_W-1:0]  cur_sec,
    input  logic [BCD_W-1:0]  cur_min,
    input  logic [BCD_W-1:0]  cur_hour,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BCD_W-1:0]  reg_wdata,
    output logic [BCD_W-1:0]  reg_rdata,
    output logic              irq_alarm,
    output logic              irq_tick
);

    now_t             now;
    cfg_t             cfg;
    logic [IRQ_N-1:0] evt;
    logic [IRQ_N-1:0] en;
    logic [IRQ_N-1:0] w1c;
    logic [IRQ_N-1:0] kill;
    logic [IRQ_N-1:0] stat;
    logic [IRQ_N-1:0] irq;
    logic             en_alm;
    logic             en_tick;

    assign now.sec  = cur_sec;
    assign now.min  = cur_min;
    assign now.hour = cur_hour;
    assign now.wday = cur_wday;

    assign en_alm      = cfg.alm_en;
    assign en_tick     = cfg.tick_en;
    assign en[CH_ALM]  = en_alm;
    assign en[CH_TICK] = en_tick;

    alm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .stat      (stat),
        .cfg       (cfg),
        .w1c       (w1c),
        .kill      (kill),
        .rdata     (reg_rdata)
    );

    alm_match u_match (
        .sec_tick (sec_tick),
        .now      (now),
        .cfg      (cfg),
        .evt      (evt)
    );

    alm_flags #(.N(IRQ_N)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .en   (en),
        .w1c  (w1c),
        .kill (kill),
        .stat (stat),
        .irq  (irq)
    );

    assign irq_alarm = irq[CH_ALM];
    assign irq_tick  = irq[CH_TICK];

endmodule

// File: rtl/alm_irq_unit_chk.sv
module alm_irq_unit_chk
    import alm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic [BCD_W-1:0]  cur_sec,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BCD_W-1:0]  reg_wdata,
    input logic              irq_alarm,
    input logic              irq_tick,
    input logic              en_alm,
    input logic              en_tick
);

    logic ctrl_wr;
    logic stat_wr;
    assign ctrl_wr = reg_wr && (reg_addr == RS_CTRL);
    assign stat_wr = reg_wr && (reg_addr == RS_STAT);

    // R3 / R4: an alarm rise needs a strobe at second zero
    p_alarm_src_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_alarm) |-> ($past(sec_tick) && $past(cur_sec) == '0));

    // R5: enabled strobe raises the tick line
    p_tick_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && en_tick && !(ctrl_wr && !reg_wdata[EN_TICK_BIT])) |=> irq_tick);

    // R6: tick line holds unless cleared
    p_tick_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_tick && !(stat_wr && reg_wdata[CH_TICK]) && !(ctrl_wr && !reg_wdata[EN_TICK_BIT]))
        |=> irq_tick);

    // R8: nothing is recorded while disabled
    p_no_record_r8: assert property (@(posedge clk) disable iff (rst)
        (!en_tick) |=> !irq_tick);

    p_no_record_alm_r8: assert property (@(posedge clk) disable iff (rst)
        (!en_alm) |=> !irq_alarm);

    // R9: writing zero to control silences both lines
    p_ctrl_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata == '0) |=> (!irq_alarm && !irq_tick));

endmodule

bind alm_irq_unit alm_irq_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick),
    .cur_sec   (cur_sec),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_alarm (irq_alarm),
    .irq_tick  (irq_tick),
    .en_alm    (en_alm),
    .en_tick   (en_tick)
);

// File: tb/alm_irq_unit_test.sv
module alm_irq_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_sec = '0;
    logic [7:0] cur_min = '0;
    logic [7:0] cur_hour = '0;
    logic [2:0] cur_wday = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_alarm;
    logic       irq_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alm_irq_unit uut (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .cur_sec   (cur_sec),
        .cur_min   (cur_min),
        .cur_hour  (cur_hour),
        .cur_wday  (cur_wday),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_alarm (irq_alarm),
        .irq_tick  (irq_tick)
    );

    // {expect_alarm, wday[2:0], sec, min, hour}; alarm set to 12:30, days 2 and 5
    localparam int NV = 10;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 3'd2, 8'h00, 8'h30, 8'h12},
        {1'b1, 3'd5, 8'h00, 8'h30, 8'h12},
        {1'b0, 3'd3, 8'h00, 8'h30, 8'h12},
        {1'b0, 3'd2, 8'h01, 8'h30, 8'h12},
        {1'b0, 3'd2, 8'h00, 8'h31, 8'h12},
        {1'b0, 3'd2, 8'h00, 8'h30, 8'h13},
        {1'b0, 3'd2, 8'h00, 8'h30, 8'h02},
        {1'b0, 3'd7, 8'h00, 8'h30, 8'h12},
        {1'b0, 3'd2, 8'h59, 8'h29, 8'h12},
        {1'b0, 3'd0, 8'h00, 8'h30, 8'h12}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [2:0] w);
        cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_alarm", {7'd0, irq_alarm}, 8'h00);
        chk("R1 irq_tick", {7'd0, irq_tick}, 8'h00);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            chk("R1 readback", r, 8'h00);
        end

        // R2 register map and kept bits
        wr(3'd0, 8'hFF); rd(3'd0, r); chk("R2 ctrl", r, 8'h18);
        wr(3'd1, 8'hFF); rd(3'd1, r); chk("R2 minute", r, 8'h7F);
        wr(3'd2, 8'hFF); rd(3'd2, r); chk("R2 hour", r, 8'h3F);
        wr(3'd3, 8'hFF); rd(3'd3, r); chk("R2 mask", r, 8'h7F);
        rd(3'd5, r); chk("R2 unused", r, 8'h00);
        wr(3'd1, 8'h30);
        wr(3'd2, 8'h12);
        wr(3'd3, 8'b0010_0100);

        // R3 R4 R10 vector walk, both enables set
        for (int i = 0; i < NV; i++) begin
            tick(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], VEC[i][26:24]);
            chk("R3/R4 alarm vector", {7'd0, irq_alarm}, {7'd0, VEC[i][27]});
            chk("R10 tick alongside", {7'd0, irq_tick}, 8'h01);
            rd(3'd4, r);
            chk("R10 status", r, {6'd0, 1'b1, VEC[i][27]});
            wr(3'd4, 8'h03);
            chk("R6 cleared", {6'd0, irq_tick, irq_alarm}, 8'h00);
        end

        // R4 no strobe, matching time
        cur_sec = 8'h00; cur_min = 8'h30; cur_hour = 8'h12; cur_wday = 3'd2;
        repeat (4) @(negedge clk);
        chk("R4 no strobe", {7'd0, irq_alarm}, 8'h00);

        // R10 independent clear: alarm bit only
        tick(8'h00, 8'h30, 8'h12, 3'd5);
        wr(3'd4, 8'h01);
        chk("R10 alarm cleared", {7'd0, irq_alarm}, 8'h00);
        chk("R10 tick kept", {7'd0, irq_tick}, 8'h01);
        wr(3'd4, 8'h02);

        // R5 tick only
        wr(3'd0, 8'h08);
        tick(8'h07, 8'h30, 8'h12, 3'd2);
        chk("R5 tick", {7'd0, irq_tick}, 8'h01);
        chk("R5 no alarm", {7'd0, irq_alarm}, 8'h00);

        // R6 sticky, other-bit and zero writes
        wr(3'd4, 8'h01);
        chk("R6 other bit", {7'd0, irq_tick}, 8'h01);
        wr(3'd4, 8'h00);
        chk("R6 zero write", {7'd0, irq_tick}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R6 held", {7'd0, irq_tick}, 8'h01);
        wr(3'd4, 8'h02);
        chk("R6 w1c", {7'd0, irq_tick}, 8'h00);

        // R7 event and clear in same cycle
        sec_tick = 1'b1; cur_sec = 8'h11;
        wr(3'd4, 8'h02);
        sec_tick = 1'b0;
        chk("R7 event wins", {7'd0, irq_tick}, 8'h01);
        wr(3'd4, 8'h02);

        // R8 events while disabled are dropped
        wr(3'd0, 8'h00);
        tick(8'h00, 8'h30, 8'h12, 3'd2);
        wr(3'd0, 8'h18);
        chk("R8 alarm", {7'd0, irq_alarm}, 8'h00);
        chk("R8 tick", {7'd0, irq_tick}, 8'h00);
        rd(3'd4, r);
        chk("R8 status", r, 8'h00);

        // R9 enable clear drops pending and beats same-cycle event
        tick(8'h00, 8'h30, 8'h12, 3'd2);
        chk("R9 setup", {6'd0, irq_tick, irq_alarm}, 8'h03);
        cur_sec = 8'h00; sec_tick = 1'b1;
        wr(3'd0, 8'h00);
        sec_tick = 1'b0;
        chk("R9 both low", {6'd0, irq_tick, irq_alarm}, 8'h00);
        rd(3'd4, r);
        chk("R9 status cleared", r, 8'h00);
        wr(3'd0, 8'h18);
        chk("R9 no revival", {6'd0, irq_tick, irq_alarm}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule